// File: doc/BRIEF.md
# Hardware Breakpoint Address Comparator

This unit is the debug breakpoint logic for a small 8-bit processor with a 16-bit address bus. Software programs a 16-bit break address as two bytes through a byte-wide register port and sets an enable bit. The unit then watches every bus cycle of the CPU. Each bus cycle carries a valid strobe and a qualifier that tells an opcode fetch from an operand or data access. When an opcode fetch hits the break address, `brk_req` rises in that same cycle. The CPU then puts a software-interrupt opcode in place of the fetched one, so the instruction at that address runs only after the break routine returns. When an operand byte hits, the instruction is allowed to finish, and the break is taken at the next opcode fetch. Software can also force a break by writing 1 to the break-active bit. That break is taken at the next opcode fetch.

While a break is taken, `vec_addr` presents the address of the interrupt vector. It is FFFC, or FEFC when monitor mode is active. The break-active state drives three side-band outputs. One freezes the timer. One gates the watchdog off in monitor mode when an auxiliary bit allows it. One passes a flag-clear permission through to the peripherals.

A match that has been taken disarms the comparator. After the break routine clears the active bit, the same address does not break again until one of the address bytes is rewritten.

Top module: `brk_unit`

Register map (`reg_sel`): 0 control (bit 7 enable, bit 6 break-active), 1 break address high byte, 2 break address low byte, 3 auxiliary (bit 0 watchdog-off permission), 4 flag control (bit 7 flag-clear enable). Other bits read 0. Other selects read 0 and ignore writes.

## Requirements
- R1: With the enable bit (control bit 7) set, the unit armed and break-active clear, an opcode fetch (`bus_valid`=1, `bus_opcode`=1) whose address equals {high byte, low byte} drives `brk_req`=1 in that same cycle.
- R2: A matching operand access (`bus_valid`=1, `bus_opcode`=0) does not drive `brk_req` in its own cycle. The break is taken at the next opcode fetch, at whatever address that fetch is.
- R3: Whenever `brk_req` is 1, `vec_addr` equals 16'hFFFC when `monitor_mode`=0 and 16'hFEFC when `monitor_mode`=1.
- R4: Writing control with bit 6 = 1 sets break-active on the next clock edge. It drives `brk_req` at the next opcode fetch after the write, and never on a cycle that is not an opcode fetch.
- R5: Taking a break sets break-active on the next clock edge. Break-active reads back as control bit 6. Writing control with bit 6 = 0 clears it and cancels a pending forced break. If a break is taken in the same cycle as such a write, the break wins.
- R6: A match that has been taken disarms the comparator. After break-active is cleared, the same address does not break again until the high or low address byte is written. Either write re-arms the comparator.
- R7: With the enable bit clear, no address match raises `brk_req`.
- R8: `tmr_freeze` is 1 exactly while break-active is set.
- R9: `wdog_off` is 1 exactly when break-active is set, `monitor_mode`=1 and auxiliary bit 0 is 1.
- R10: `flag_clr_en` always equals flag-control bit 7.
- R11: Reset clears every register, break-active and any pending break. `reg_rdata` is combinational and returns the current contents of the selected register, with unused bits and selects 5 to 7 reading 0.
- R12: While break-active is set, address matches are ignored, so the break routine's own fetches cannot re-trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Selected register contents |
| bus_valid | input | 1 | CPU bus cycle valid |
| bus_opcode | input | 1 | 1 = opcode fetch, 0 = operand/data access |
| bus_addr | input | 16 | CPU internal address |
| monitor_mode | input | 1 | Monitor mode active |
| brk_req | output | 1 | Replace this fetch with the software-interrupt opcode |
| vec_addr | output | 16 | Vector address for the break |
| tmr_freeze | output | 1 | Stop the timer counter |
| wdog_off | output | 1 | Disable the watchdog |
| flag_clr_en | output | 1 | Peripheral status flags may be cleared during break |

## Verification
The bench first aims at the timing split between opcode and operand matches. If it gets this wrong, a design breaks on the operand cycle itself, or it drops the deferred break. It then goes after the re-fire rule. Clearing break-active with the address unchanged must stay silent, and rewriting only the low byte must re-arm. A design that compares only after a write, or never disarms, would either miss the repeat break or break in a loop. It also checks that a forced break waits through operand cycles, and that a clearing write in the same cycle as a take loses to the take. It checks that matches during the break routine are ignored, and that the watchdog gate follows monitor mode cycle by cycle. A reference model in the bench checks every cycle of a long random run against the same rules.

// File: rtl/brk_pkg.sv
`timescale 1ns/1ps
package brk_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL = 3'd0,
    SEL_BAH  = 3'd1,
    SEL_BAL  = 3'd2,
    SEL_AUX  = 3'd3,
    SEL_FLAG = 3'd4
  } brk_sel_e;

  // bit positions inside the byte-wide registers
  localparam int CTRL_EN_BIT  = 7;
  localparam int CTRL_ACT_BIT = 6;
  localparam int AUX_WDOG_BIT = 0;
  localparam int FLAG_CLR_BIT = 7;

  function automatic logic addr_hit(input logic [15:0] a, input logic [15:0] b);
    return a == b;
  endfunction

  function automatic logic [15:0] pick_vector(input logic mon,
                                              input logic [15:0] v_norm,
                                              input logic [15:0] v_mon);
    return mon ? v_mon : v_norm;
  endfunction
endpackage

// File: rtl/brk_regfile.sv
`timescale 1ns/1ps
module brk_regfile
  import brk_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              active_i,
  output logic              en_o,
  output logic [ADDR_W-1:0] baddr_o,
  output logic              wdog_aux_o,
  output logic              fce_o,
  output logic              wr_ctrl_o,
  output logic              wr_addr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] addr_byte_q [2];
  logic en_q, wdog_q, fce_q;

  assign wr_ctrl_o = reg_wr && (reg_sel == SEL_CTRL);
  assign wr_addr_o = reg_wr && ((reg_sel == SEL_BAH) || (reg_sel == SEL_BAL));

  // one storage byte per half of the break address
  for (genvar b = 0; b < 2; b++) begin : g_addr_byte
    localparam logic [SEL_W-1:0] MY_SEL = (b == 1) ? SEL_BAH : SEL_BAL;
    always_ff @(posedge clk) begin
      if (!rst_n)
        addr_byte_q[b] <= '0;
      else if (reg_wr && (reg_sel == MY_SEL))
        addr_byte_q[b] <= reg_wdata;
    end
  end

  assign baddr_o = {addr_byte_q[1], addr_byte_q[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      wdog_q <= 1'b0;
      fce_q  <= 1'b0;
    end else if (reg_wr) begin
      if (reg_sel == SEL_CTRL) en_q   <= reg_wdata[CTRL_EN_BIT];
      if (reg_sel == SEL_AUX)  wdog_q <= reg_wdata[AUX_WDOG_BIT];
      if (reg_sel == SEL_FLAG) fce_q  <= reg_wdata[FLAG_CLR_BIT];
    end
  end

  assign en_o       = en_q;
  assign wdog_aux_o = wdog_q;
  assign fce_o      = fce_q;

  always_comb begin
    rdata_o = '0;
    case (reg_sel)
      SEL_CTRL: begin
        rdata_o[CTRL_EN_BIT]  = en_q;
        rdata_o[CTRL_ACT_BIT] = active_i;
      end
      SEL_BAH:  rdata_o = addr_byte_q[1];
      SEL_BAL:  rdata_o = addr_byte_q[0];
      SEL_AUX:  rdata_o[AUX_WDOG_BIT] = wdog_q;
      SEL_FLAG: rdata_o[FLAG_CLR_BIT] = fce_q;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/brk_ctl.sv
`timescale 1ns/1ps
module brk_ctl
  import brk_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_opcode,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] baddr_i,
  input  logic              wr_ctrl_i,
  input  logic              wr_act_val_i,
  input  logic              wr_addr_i,
  output logic              hit_o,
  output logic              take_o,
  output logic              active_o,
  output logic              armed_o,
  output logic              opnd_pend_o,
  output logic              force_pend_o
);
  logic active_q, armed_q, opnd_q, force_q;
  logic opfetch;

  assign opfetch = bus_valid && bus_opcode;

  // comparator is live only when enabled, armed and outside a break
  assign hit_o = en_i && armed_q && !active_q && bus_valid &&
                 addr_hit(bus_addr, baddr_i);

  // opcode hit replaces this fetch; deferred causes wait for a fetch
  assign take_o = opfetch && (force_q || opnd_q || hit_o);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      armed_q  <= 1'b1;
      opnd_q   <= 1'b0;
      force_q  <= 1'b0;
    end else begin
      // break-active: a take outranks a clearing write
      if (take_o)         active_q <= 1'b1;
      else if (wr_ctrl_i) active_q <= wr_act_val_i;

      // forced break: writing the control register sets or cancels it
      if (wr_ctrl_i)   force_q <= wr_act_val_i;
      else if (take_o) force_q <= 1'b0;

      // operand hit waits for the next opcode fetch
      if (take_o)                  opnd_q <= 1'b0;
      else if (hit_o && !bus_opcode) opnd_q <= 1'b1;

      // one shot per programmed address
      if (wr_addr_i)  armed_q <= 1'b1;
      else if (hit_o) armed_q <= 1'b0;
    end
  end

  assign active_o     = active_q;
  assign armed_o      = armed_q;
  assign opnd_pend_o  = opnd_q;
  assign force_pend_o = force_q;
endmodule

// File: rtl/brk_side.sv
`timescale 1ns/1ps
module brk_side
  import brk_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VEC_NORMAL  = 16'hFFFC,
  parameter logic [ADDR_W-1:0] VEC_MONITOR = 16'hFEFC
) (
  input  logic              active_i,
  input  logic              monitor_mode,
  input  logic              wdog_aux_i,
  input  logic              fce_i,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              tmr_freeze,
  output logic              wdog_off,
  output logic              flag_clr_en
);
  assign vec_addr    = pick_vector(monitor_mode, VEC_NORMAL, VEC_MONITOR);
  assign tmr_freeze  = active_i;
  assign wdog_off    = active_i && monitor_mode && wdog_aux_i;
  assign flag_clr_en = fce_i;
endmodule

// File: rtl/brk_unit.sv
`timescale 1ns/1ps
module brk_unit
  import brk_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W,
  parameter logic [ADDR_W-1:0] VEC_NORMAL  = 16'hFFFC,
  parameter logic [ADDR_W-1:0] VEC_MONITOR = 16'hFEFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              bus_valid,
  input  logic              bus_opcode,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              monitor_mode,
  output logic              brk_req,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              tmr_freeze,
  output logic              wdog_off,
  output logic              flag_clr_en
);
  // named internal events, also observed by the bound checker
  logic              en, wdog_aux, fce;
  logic [ADDR_W-1:0] baddr;
  logic              wr_ctrl, wr_addr, wr_force;
  logic              hit, take, active, armed, opnd_pend, force_pend;

  assign wr_force = wr_ctrl && reg_wdata[CTRL_ACT_BIT];

  brk_regfile #(.DATA_W(DATA_W)) i_regs (
    .clk, .rst_n, .reg_wr, .reg_sel, .reg_wdata,
    .active_i(active), .en_o(en), .baddr_o(baddr), .wdog_aux_o(wdog_aux),
    .fce_o(fce), .wr_ctrl_o(wr_ctrl), .wr_addr_o(wr_addr), .rdata_o(reg_rdata)
  );

  brk_ctl #(.ADDR_W(ADDR_W)) i_ctl (
    .clk, .rst_n, .bus_valid, .bus_opcode, .bus_addr,
    .en_i(en), .baddr_i(baddr), .wr_ctrl_i(wr_ctrl),
    .wr_act_val_i(reg_wdata[CTRL_ACT_BIT]), .wr_addr_i(wr_addr),
    .hit_o(hit), .take_o(take), .active_o(active), .armed_o(armed),
    .opnd_pend_o(opnd_pend), .force_pend_o(force_pend)
  );

  brk_side #(.ADDR_W(ADDR_W), .VEC_NORMAL(VEC_NORMAL), .VEC_MONITOR(VEC_MONITOR)) i_side (
    .active_i(active), .monitor_mode, .wdog_aux_i(wdog_aux), .fce_i(fce),
    .vec_addr, .tmr_freeze, .wdog_off, .flag_clr_en
  );

  assign brk_req = take;
endmodule

// File: rtl/brk_chk.sv
`timescale 1ns/1ps
module brk_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VEC_NORMAL  = 16'hFFFC,
  parameter logic [ADDR_W-1:0] VEC_MONITOR = 16'hFEFC
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_opcode,
  input logic              monitor_mode,
  input logic              brk_req,
  input logic [ADDR_W-1:0] vec_addr,
  input logic              tmr_freeze,
  input logic              wdog_off,
  input logic              en,
  input logic              hit,
  input logic              active,
  input logic              armed,
  input logic              opnd_pend,
  input logic              force_pend,
  input logic              wr_addr,
  input logic              wr_force
);
  assert_opcode_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && bus_opcode) |-> brk_req);

  assert_operand_waits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !bus_opcode) |-> !brk_req);

  assert_operand_pends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !bus_opcode) |=> opnd_pend);

  assert_vector_R3: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> (vec_addr == (monitor_mode ? VEC_MONITOR : VEC_NORMAL)));

  assert_req_on_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> (bus_valid && bus_opcode));

  assert_take_activates_R5: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |=> active);

  assert_disarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (!armed || $past(wr_addr)));

  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !force_pend && !opnd_pend) |-> !brk_req);

  assert_freeze_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmr_freeze) |-> $past(brk_req || wr_force));

  assert_wdog_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_off |-> (monitor_mode && tmr_freeze));

  assert_routine_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !force_pend && !opnd_pend) |-> !brk_req);
endmodule

bind brk_unit brk_chk #(.ADDR_W(ADDR_W), .VEC_NORMAL(VEC_NORMAL), .VEC_MONITOR(VEC_MONITOR)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_opcode(bus_opcode),
  .monitor_mode(monitor_mode), .brk_req(brk_req), .vec_addr(vec_addr),
  .tmr_freeze(tmr_freeze), .wdog_off(wdog_off), .en(en), .hit(hit),
  .active(active), .armed(armed), .opnd_pend(opnd_pend),
  .force_pend(force_pend), .wr_addr(wr_addr), .wr_force(wr_force)
);

// File: tb/test_brk_unit.sv
`timescale 1ns/1ps
module test_brk_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        bus_valid = 1'b0, bus_opcode = 1'b0, monitor_mode = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        brk_req, tmr_freeze, wdog_off, flag_clr_en;
  logic [15:0] vec_addr;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference state, kept from the requirements
  bit         m_en, m_armed, m_act, m_force, m_opnd, m_wd, m_fce;
  logic [15:0] m_baddr;

  brk_unit i_brk_unit (
    .clk, .rst_n, .reg_wr, .reg_sel, .reg_wdata, .reg_rdata,
    .bus_valid, .bus_opcode, .bus_addr, .monitor_mode,
    .brk_req, .vec_addr, .tmr_freeze, .wdog_off, .flag_clr_en
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] want_vec(input logic mon);
    return mon ? 16'hFEFC : 16'hFFFC;
  endfunction

  function automatic logic [7:0] want_rdata(input logic [2:0] s);
    case (s)
      3'd0: return {m_en, m_act, 6'b0};
      3'd1: return m_baddr[15:8];
      3'd2: return m_baddr[7:0];
      3'd3: return {7'b0, m_wd};
      3'd4: return {m_fce, 7'b0};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_en = 0; m_armed = 1; m_act = 0; m_force = 0; m_opnd = 0;
    m_wd = 0; m_fce = 0; m_baddr = '0;
  endtask

  // one bus cycle: drive at negedge, compare before the edge, advance model
  task automatic cycle(input logic v, input logic op, input logic [15:0] a, input logic mon,
                       input logic wr, input logic [2:0] sel, input logic [7:0] wd);
    bit hit, take;
    @(negedge clk);
    bus_valid = v; bus_opcode = op; bus_addr = a; monitor_mode = mon;
    reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    #1;
    hit  = m_en && m_armed && !m_act && v && (a == m_baddr);
    take = v && op && (m_force || m_opnd || hit);
    chk(brk_req === take, "R1 R2 R4 R6 R7 R12 brk_req", brk_req, take);
    if (take) chk(vec_addr === want_vec(mon), "R3 vec_addr", vec_addr, want_vec(mon));
    chk(tmr_freeze === m_act, "R8 tmr_freeze", tmr_freeze, m_act);
    chk(wdog_off === (m_act && mon && m_wd), "R9 wdog_off", wdog_off, m_act && mon && m_wd);
    chk(flag_clr_en === m_fce, "R10 flag_clr_en", flag_clr_en, m_fce);
    chk(reg_rdata === want_rdata(sel), "R5 R11 reg_rdata", reg_rdata, want_rdata(sel));
    // state update at the coming edge
    if (take) m_act = 1; else if (wr && sel == 3'd0) m_act = wd[6];
    if (wr && sel == 3'd0) m_force = wd[6]; else if (take) m_force = 0;
    if (take) m_opnd = 0; else if (hit && !op) m_opnd = 1;
    if (wr && (sel == 3'd1 || sel == 3'd2)) m_armed = 1; else if (hit) m_armed = 0;
    if (wr) begin
      case (sel)
        3'd0: m_en = wd[7];
        3'd1: m_baddr[15:8] = wd;
        3'd2: m_baddr[7:0] = wd;
        3'd3: m_wd = wd[0];
        3'd4: m_fce = wd[7];
        default: ;
      endcase
    end
  endtask

  task automatic wreg(input logic [2:0] sel, input logic [7:0] wd);
    cycle(1'b0, 1'b0, 16'h0000, monitor_mode, 1'b1, sel, wd);
  endtask

  task automatic fetch(input logic op, input logic [15:0] a, input logic mon);
    cycle(1'b1, op, a, mon, 1'b0, 3'd0, 8'h00);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    int seed;
    seed = 32'h5eed_b7a3;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R11: reset contents of every select
    for (int s = 0; s < 8; s++) cycle(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, s[2:0], 8'h00);

    // R1, R3: opcode hit breaks in the same cycle
    wreg(3'd1, 8'h12); wreg(3'd2, 8'h34); wreg(3'd0, 8'h80);
    fetch(1'b1, 16'h1234, 1'b0);
    chk(brk_req === 1'b1, "R1 opcode hit", brk_req, 1);
    chk(vec_addr === 16'hFFFC, "R3 normal vector", vec_addr, 16'hFFFC);
    // R8, R5: break state visible next cycle
    cycle(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 3'd0, 8'h00);
    chk(tmr_freeze === 1'b1, "R8 freeze in break", tmr_freeze, 1);
    chk(reg_rdata === 8'hC0, "R5 active readback", reg_rdata, 8'hC0);
    // R12: routine fetch of the same address is ignored
    fetch(1'b1, 16'h1234, 1'b0);
    chk(brk_req === 1'b0, "R12 quiet in break", brk_req, 0);
    // R6: clear without rewrite: no repeat
    wreg(3'd0, 8'h80);
    fetch(1'b1, 16'h1234, 1'b0);
    chk(brk_req === 1'b0, "R6 no refire", brk_req, 0);
    // R6, R3: rewrite low byte only re-arms; monitor vector
    wreg(3'd2, 8'h34);
    fetch(1'b1, 16'h1234, 1'b1);
    chk(brk_req === 1'b1, "R6 rearm", brk_req, 1);
    chk(vec_addr === 16'hFEFC, "R3 monitor vector", vec_addr, 16'hFEFC);
    // R2: operand hit deferred to next opcode fetch
    wreg(3'd0, 8'h80); wreg(3'd2, 8'h35);
    fetch(1'b0, 16'h1235, 1'b0);
    chk(brk_req === 1'b0, "R2 operand cycle", brk_req, 0);
    fetch(1'b0, 16'h1236, 1'b0);
    fetch(1'b1, 16'h2000, 1'b0);
    chk(brk_req === 1'b1, "R2 deferred take", brk_req, 1);
    // R7: disabled
    wreg(3'd0, 8'h00); wreg(3'd2, 8'h35);
    fetch(1'b1, 16'h1235, 1'b0);
    chk(brk_req === 1'b0, "R7 disabled", brk_req, 0);
    // R4: forced break waits through operand cycles
    wreg(3'd0, 8'h40);
    fetch(1'b0, 16'h4000, 1'b0);
    chk(brk_req === 1'b0, "R4 force not on operand", brk_req, 0);
    fetch(1'b1, 16'h4001, 1'b0);
    chk(brk_req === 1'b1, "R4 force taken", brk_req, 1);
    // R9, R10: watchdog gate and flag permission
    wreg(3'd3, 8'h01); wreg(3'd4, 8'h80);
    cycle(1'b0, 1'b0, 16'h0, 1'b1, 1'b0, 3'd3, 8'h00);
    chk(wdog_off === 1'b1, "R9 wdog off in monitor", wdog_off, 1);
    cycle(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 3'd4, 8'h00);
    chk(wdog_off === 1'b0, "R9 wdog on outside monitor", wdog_off, 0);
    chk(flag_clr_en === 1'b1, "R10 flag clear", flag_clr_en, 1);
    // R5: take outranks a clearing write in the same cycle
    wreg(3'd0, 8'h80); wreg(3'd2, 8'h35);
    cycle(1'b1, 1'b1, 16'h1235, 1'b0, 1'b1, 3'd0, 8'h80);
    chk(brk_req === 1'b1, "R5 take with write", brk_req, 1);
    cycle(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 3'd0, 8'h00);
    chk(reg_rdata[6] === 1'b1, "R5 take wins", reg_rdata[6], 1);

    // constrained random run against the model
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      logic [2:0]  sel;
      logic [7:0]  wd;
      logic        wr;
      a   = ($urandom % 3 == 0) ? m_baddr : (($urandom % 2 == 0) ? {m_baddr[15:2], 2'($urandom)} : 16'($urandom));
      wr  = ($urandom % 6 == 0);
      sel = 3'($urandom % 6);
      wd  = 8'($urandom);
      if (sel == 3'd0) wd[7] = ($urandom % 5 != 0);
      if (sel == 3'd0) wd[6] = ($urandom % 4 == 0);
      cycle($urandom % 4 != 0, $urandom % 2, a, $urandom % 2, wr, sel, wd);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule